// File: doc/BRIEF.md
# Full-Bridge Dead-Time Phase Sequencer

This block produces the four gate-enable signals of a full bridge: two low-side enables and two high-side enables. The switches are driven in diagonal pairs. Low side 1 goes with high side 2, and low side 2 goes with high side 1. Each pair conducts for the same length of time, so the duty cycle is 50%. Between the two pairs the block holds every enable low for a selectable dead time. The period comes from a programmable half-period count in clock cycles, which takes the place of an analog timing ramp.

Supply supervision works on two digital indications, one for "above the turn-on level" and one for "below the turn-off level". Between the two levels the block keeps its current on/off state, which gives hysteresis. Before the first switching cycle, and again after a hold is released, both low sides are enabled for one half-period so the high-side bootstrap supplies can charge. A hold input freezes switching with the low sides on. A shutdown input forces a fault state with every enable low. That state is kept until the supply indication falls below the turn-off level and then returns above the turn-on level.

Top module: `fb_phase_seq`

## Requirements
- R1: After reset, and while the supply has not yet been seen above the turn-on level, all four enables are low. Being between the two levels does not turn the block on.
- R2: Once the block is on, it keeps switching while the turn-on indication is low, as long as the turn-off indication stays low. When the turn-off indication is sampled high at a clock edge, all enables are low after that same edge.
- R3: The supply is recognised as on at one edge. After the next edge, lo1 and lo2 are both high, with hi1 and hi2 low, for exactly cfg_half cycles (the precharge interval).
- R4: Switching alternates two patterns. Phase A has lo1 and hi2 high. Phase B has lo2 and hi1 high. Each pair rises together and falls together. After precharge a dead time follows, then phase A.
- R5: Each phase stays on for cfg_half minus the dead time in cycles. A full period is 2*cfg_half cycles, with equal A and B halves.
- R6: Every pair-to-pair change, and the change from precharge to phase A, has exactly DT cycles with all enables low. DT is DT_LONG when cfg_dt_long is 1 and DT_SHORT when it is 0.
- R7: When hold_req is sampled high at an edge (supply on, no fault), the block shows lo1 and lo2 high and hi1 and hi2 low after that edge, for as long as the hold lasts. The edge that samples the hold low starts a new precharge interval of cfg_half cycles.
- R8: When shut_req is high at two consecutive edges, all enables are low after the second of those edges, even if hold_req is high.
- R9: Shutdown is latched. Enables stay low after shut_req and hold_req are released. The latch clears only when the turn-off indication is sampled high. A later turn-on restarts the sequence from precharge.
- R10: If cfg_half is not greater than the selected dead time, all enables are low one edge later. cfg_half equal to the dead time plus 1 is valid and gives a one-cycle phase.
- R11: lo1 and hi1 are never high together, and lo2 and hi2 are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| vdd_above_on | input | 1 | Supply is above the turn-on level |
| vdd_below_off | input | 1 | Supply is below the turn-off level |
| shut_req | input | 1 | Latched shutdown request, asynchronous |
| hold_req | input | 1 | Non-latched hold request |
| cfg_half | input | HALF_W | Half-period length in clock cycles |
| cfg_dt_long | input | 1 | 1 selects DT_LONG, 0 selects DT_SHORT |
| lo1_en | output | 1 | Low-side 1 enable |
| lo2_en | output | 1 | Low-side 2 enable |
| hi1_en | output | 1 | High-side 1 enable |
| hi2_en | output | 1 | High-side 2 enable |

## Verification
A wrong phase state or a bad timer count shows up at the ports within one half-period. It appears as a wrong pattern, a phase that is too long or too short, or a dead-time gap of the wrong length. The scoreboard compares the enables against the expected pattern on every cycle, so any such error is caught at the first cycle where it differs. A supervision latch that clears or sets wrongly shows up at the first edge after a supply or shutdown event: the enables either resume when they should stay low or stay low when they should restart precharge. A fault in the pairing or the dead-time logic, including a same-leg overlap, is caught in the cycle it happens.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic [2:0] {
      PH_OFF  = 3'd0,
      PH_PRE  = 3'd1,
      PH_HOLD = 3'd2,
      PH_AON  = 3'd3,
      PH_DTA  = 3'd4,
      PH_BON  = 3'd5,
      PH_DTB  = 3'd6
   } fbs_phase_e;

   typedef struct packed {
      logic hi2;
      logic hi1;
      logic lo2;
      logic lo1;
   } fbs_gate_t;

   localparam fbs_gate_t GATE_NONE = '{hi2: 1'b0, hi1: 1'b0, lo2: 1'b0, lo1: 1'b0};
   localparam fbs_gate_t GATE_LOWS = '{hi2: 1'b0, hi1: 1'b0, lo2: 1'b1, lo1: 1'b1};
   localparam fbs_gate_t GATE_A    = '{hi2: 1'b1, hi1: 1'b0, lo2: 1'b0, lo1: 1'b1};
   localparam fbs_gate_t GATE_B    = '{hi2: 1'b0, hi1: 1'b1, lo2: 1'b1, lo1: 1'b0};

endpackage

// File: rtl/fbs_sync.sv
module fbs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      logic r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) r <= 1'b0;
            else        r <= g_st[i-1].r;
         end
      end
   end

   assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/fbs_guard.sv
module fbs_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic above_on,
   input  logic below_off,
   input  logic shut_s,
   input  logic cfg_valid,
   output logic run
);

   logic sup_ok;
   logic fault;
   logic cfg_ok_q;

   // supply on/off with hysteresis: turn on above upper level, off below lower
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sup_ok <= 1'b0;
      end else if (sup_ok) begin
         if (below_off) sup_ok <= 1'b0;
      end else if (above_on) begin
         sup_ok <= 1'b1;
      end
   end

   // latched fault: set by synchronised shutdown, cleared only by supply drop
   always_ff @(posedge clk) begin
      if (!rst_n)         fault <= 1'b0;
      else if (shut_s)    fault <= 1'b1;
      else if (below_off) fault <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cfg_ok_q <= 1'b0;
      else        cfg_ok_q <= cfg_valid;
   end

   assign run = sup_ok & ~fault & cfg_ok_q & ~shut_s;

endmodule

// File: rtl/fbs_timer.sv
module fbs_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/fbs_fsm.sv
module fbs_fsm
   import fbs_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         hold,
   input  logic [W-1:0] half,
   input  logic [W-1:0] dt,
   input  logic         done,
   output logic         load,
   output logic [W-1:0] load_val,
   output fbs_gate_t    gate
);

   fbs_phase_e ph, ph_nxt;
   logic [W-1:0] on_len;
   logic [W-1:0] dt_len;
   logic [W-1:0] pre_len;

   assign on_len  = half - dt - 1'b1;
   assign dt_len  = dt - 1'b1;
   assign pre_len = half - 1'b1;

   always_comb begin
      ph_nxt   = ph;
      load     = 1'b0;
      load_val = '0;
      if (!run) begin
         ph_nxt = PH_OFF;
      end else if (hold) begin
         ph_nxt = PH_HOLD;
      end else begin
         unique case (ph)
            PH_OFF, PH_HOLD: begin
               ph_nxt = PH_PRE; load = 1'b1; load_val = pre_len;
            end
            PH_PRE: if (done) begin
               ph_nxt = PH_DTB; load = 1'b1; load_val = dt_len;
            end
            PH_DTB: if (done) begin
               ph_nxt = PH_AON; load = 1'b1; load_val = on_len;
            end
            PH_AON: if (done) begin
               ph_nxt = PH_DTA; load = 1'b1; load_val = dt_len;
            end
            PH_DTA: if (done) begin
               ph_nxt = PH_BON; load = 1'b1; load_val = on_len;
            end
            PH_BON: if (done) begin
               ph_nxt = PH_DTB; load = 1'b1; load_val = dt_len;
            end
            default: ph_nxt = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph <= PH_OFF;
      else        ph <= ph_nxt;
   end

   always_comb begin
      unique case (ph)
         PH_PRE, PH_HOLD: gate = GATE_LOWS;
         PH_AON:          gate = GATE_A;
         PH_BON:          gate = GATE_B;
         default:         gate = GATE_NONE;
      endcase
   end

endmodule

// File: rtl/fb_phase_seq.sv
module fb_phase_seq
   import fbs_pkg::*;
#(
   parameter int HALF_W      = 16,
   parameter int DT_LONG     = 200,
   parameter int DT_SHORT    = 100,
   parameter bit DT_SEL_EN   = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vdd_above_on,
   input  logic              vdd_below_off,
   input  logic              shut_req,
   input  logic              hold_req,
   input  logic [HALF_W-1:0] cfg_half,
   input  logic              cfg_dt_long,
   output logic              lo1_en,
   output logic              lo2_en,
   output logic              hi1_en,
   output logic              hi2_en
);

   localparam logic [HALF_W-1:0] DT_L = HALF_W'(DT_LONG);
   localparam logic [HALF_W-1:0] DT_S = HALF_W'(DT_SHORT);

   if (DT_SHORT < 1) begin : g_bad_short
      $error("fb_phase_seq: DT_SHORT must be at least 1");
   end
   if (DT_LONG < DT_SHORT) begin : g_bad_long
      $error("fb_phase_seq: DT_LONG must not be below DT_SHORT");
   end
   if (DT_LONG + 1 >= (2 ** HALF_W)) begin : g_bad_width
      $error("fb_phase_seq: HALF_W too narrow for DT_LONG");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fb_phase_seq: SYNC_STAGES must be at least 2");
   end

   logic [HALF_W-1:0] dt_cyc;

   if (DT_SEL_EN) begin : g_dt_sel
      assign dt_cyc = cfg_dt_long ? DT_L : DT_S;
   end else begin : g_dt_fix
      logic unused_sel;
      assign unused_sel = cfg_dt_long;
      assign dt_cyc     = DT_L;
   end

   logic      shut_s;
   logic      run;
   logic      load;
   logic      done;
   logic [HALF_W-1:0] load_val;
   fbs_gate_t gate;

   fbs_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (shut_req),
      .q     (shut_s)
   );

   fbs_guard guard_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .above_on  (vdd_above_on),
      .below_off (vdd_below_off),
      .shut_s    (shut_s),
      .cfg_valid (cfg_half > dt_cyc),
      .run       (run)
   );

   fbs_timer #(.W(HALF_W)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .done     (done)
   );

   fbs_fsm #(.W(HALF_W)) fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .hold     (hold_req),
      .half     (cfg_half),
      .dt       (dt_cyc),
      .done     (done),
      .load     (load),
      .load_val (load_val),
      .gate     (gate)
   );

   assign lo1_en = gate.lo1 & run;
   assign lo2_en = gate.lo2 & run;
   assign hi1_en = gate.hi1 & run;
   assign hi2_en = gate.hi2 & run;

endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
   parameter int HALF_W    = 16,
   parameter int DT_LONG   = 200,
   parameter int DT_SHORT  = 100,
   parameter bit DT_SEL_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shut_req,
   input logic              hold_req,
   input logic [HALF_W-1:0] cfg_half,
   input logic              cfg_dt_long,
   input logic              lo1_en,
   input logic              lo2_en,
   input logic              hi1_en,
   input logic              hi2_en
);

   logic [3:0] outs;
   logic [HALF_W-1:0] dt_now;
   assign outs   = {hi2_en, hi1_en, lo2_en, lo1_en};
   assign dt_now = (DT_SEL_EN && !cfg_dt_long) ? HALF_W'(DT_SHORT) : HALF_W'(DT_LONG);

   // R11
   leg1_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lo1_en && hi1_en));

   // R11
   leg2_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lo2_en && hi2_en));

   // R4
   diag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi2_en |-> (lo1_en && !lo2_en)) and (hi1_en |-> (lo2_en && !lo1_en)));

   // R6
   dt_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi1_en) || $rose(hi2_en)) |-> $past(outs == 4'b0000));

   // R7
   hold_lows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold_req) |-> (outs == 4'b0000 || outs == 4'b0011));

   // R8
   shut_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(shut_req, 2) |-> (outs == 4'b0000));

   // R10
   cfg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_half) <= $past(dt_now)) |-> (outs == 4'b0000));

endmodule

bind fb_phase_seq fbs_chk #(
   .HALF_W    (HALF_W),
   .DT_LONG   (DT_LONG),
   .DT_SHORT  (DT_SHORT),
   .DT_SEL_EN (DT_SEL_EN)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .shut_req    (shut_req),
   .hold_req    (hold_req),
   .cfg_half    (cfg_half),
   .cfg_dt_long (cfg_dt_long),
   .lo1_en      (lo1_en),
   .lo2_en      (lo2_en),
   .hi1_en      (hi1_en),
   .hi2_en      (hi2_en)
);

// File: tb/fb_phase_seq_tb_top.sv
`timescale 1ns/100ps
module fb_phase_seq_tb_top;

   localparam int HW  = 8;
   localparam int DTL = 6;
   localparam int DTS = 3;
   localparam logic [3:0] P0   = 4'b0000;
   localparam logic [3:0] PLOW = 4'b0011;
   localparam logic [3:0] PA   = 4'b1001;
   localparam logic [3:0] PB   = 4'b0110;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vdd_above_on = 1'b0;
   logic vdd_below_off = 1'b1;
   logic shut_req = 1'b0;
   logic hold_req = 1'b0;
   logic [HW-1:0] cfg_half = HW'(10);
   logic cfg_dt_long = 1'b1;
   logic lo1_en, lo2_en, hi1_en, hi2_en;

   always #2.5 clk = ~clk;

   fb_phase_seq #(
      .HALF_W(HW), .DT_LONG(DTL), .DT_SHORT(DTS), .DT_SEL_EN(1'b1), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .vdd_above_on(vdd_above_on), .vdd_below_off(vdd_below_off),
      .shut_req(shut_req), .hold_req(hold_req), .cfg_half(cfg_half), .cfg_dt_long(cfg_dt_long),
      .lo1_en(lo1_en), .lo2_en(lo2_en), .hi1_en(hi1_en), .hi2_en(hi2_en)
   );

   int total = 0;
   int bad = 0;
   logic [3:0] exp_q[$];
   logic       care_q[$];
   string      tag_q[$];

   logic [3:0] got, e;
   logic       c;
   string      t;

   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         c = care_q.pop_front();
         t = tag_q.pop_front();
         got = {hi2_en, hi1_en, lo2_en, lo1_en};
         if (c) begin
            total++;
            if (got !== e) begin
               bad++;
               $display("FAIL %s: enables actual=%b expected=%b at %0t", t, got, e, $time);
            end
         end
      end
   end

   // one clock edge: the expected pattern describes the enables after it
   task automatic tick(input logic [3:0] x, input logic cr, input string tag);
      @(posedge clk);
      exp_q.push_back(x);
      care_q.push_back(cr);
      tag_q.push_back(tag);
      #1;
   endtask

   task automatic seg(input logic [3:0] x, input int n, input string tag);
      for (int i = 0; i < n; i++) tick(x, 1'b1, tag);
   endtask

   task automatic startup(input int h, input int dt);
      seg(P0, 1, "R3");
      seg(PLOW, h, "R3");
      seg(P0, dt, "R6");
   endtask

   task automatic periods(input int h, input int dt, input int n);
      for (int k = 0; k < n; k++) begin
         seg(PA, h - dt, "R5");
         seg(P0, dt, "R6");
         seg(PB, h - dt, "R4");
         seg(P0, dt, "R6");
      end
   endtask

   initial begin
      #(5.0 * 20000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if ({hi2_en, hi1_en, lo2_en, lo1_en} !== P0) begin
         bad++;
         $display("FAIL R1: reset enables actual=%b expected=%b", {hi2_en, hi1_en, lo2_en, lo1_en}, P0);
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      seg(P0, 3, "R1");
      // between the two levels: must not turn on (R1)
      vdd_below_off = 1'b0;
      seg(P0, 5, "R1");
      // turn on, long dead time (R3, R4, R5, R6)
      vdd_above_on = 1'b1;
      startup(10, DTL);
      periods(10, DTL, 2);
      // hysteresis band: keeps switching (R2)
      vdd_above_on = 1'b0;
      periods(10, DTL, 1);
      vdd_below_off = 1'b1;
      seg(P0, 4, "R2");
      // restart with short dead time (R6)
      vdd_below_off = 1'b0;
      cfg_dt_long = 1'b0;
      vdd_above_on = 1'b1;
      startup(10, DTS);
      periods(10, DTS, 2);
      seg(PA, 4, "R5");
      // hold mid-phase (R7)
      hold_req = 1'b1;
      seg(PLOW, 8, "R7");
      hold_req = 1'b0;
      seg(PLOW, 10, "R7");
      seg(P0, DTS, "R7");
      periods(10, DTS, 1);
      // shutdown with hold also high: shutdown wins (R8)
      shut_req = 1'b1;
      hold_req = 1'b1;
      tick(P0, 1'b0, "R8");
      seg(P0, 5, "R8");
      // latched after release (R9)
      shut_req = 1'b0;
      hold_req = 1'b0;
      seg(P0, 6, "R9");
      vdd_above_on = 1'b0;
      vdd_below_off = 1'b1;
      seg(P0, 1, "R9");
      vdd_below_off = 1'b0;
      vdd_above_on = 1'b1;
      startup(10, DTS);
      periods(10, DTS, 1);
      // invalid half-period (R10)
      cfg_half = HW'(DTS);
      seg(P0, 6, "R10");
      // boundary: half = dead time + 1 (R10)
      cfg_half = HW'(DTS + 1);
      startup(DTS + 1, DTS);
      periods(DTS + 1, DTS, 2);
      @(negedge clk); @(negedge clk); #1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule